// File: doc/BRIEF.md
# Dual-Channel Tone Gating Generator

This block derives a square-wave tone from a single oscillator and steers it independently onto two output channels. The oscillator is modelled inside the block as a square wave whose half period is a parameterised number of cycles of the block clock. The tone runs at one tenth of the oscillator rate with equal high and low halves. The same oscillator square wave also leaves the block once per channel as the switching clock for that channel's converter.

Each channel has three controls. A channel enable powers the channel and its converter clock. A continuous-tone bit forces the tone on. An asynchronous keying pin lets the tone through in bursts while it is high and the continuous bit is clear. The keying pins pass through a two-flop synchronizer. A channel's tone gate changes only at the start of a tone period, so every burst holds whole tone cycles. Wave shaping and injection into the supply rail happen outside the block.

Top module: `tone_gate_gen`

## Requirements
- R1: With the tone present, one tone period equals 10 oscillator periods, which is 20·OSC_HALF block clocks.
- R2: Each tone period is high for exactly 5 oscillator periods (10·OSC_HALF block clocks) and low for the rest, giving a 50% duty cycle.
- R3: An enabled channel whose continuous bit is 1 carries the tone without interruption, whatever its keying pin does.
- R4: An enabled channel whose continuous bit is 0 carries the tone only in tone periods that start while its synchronized keying pin is high.
- R5: The two channels are gated independently. Both may carry the tone at once, and their tones and converter clocks are in phase.
- R6: conv_clk[i] is the oscillator square wave, registered, while chan_en[i] is 1. It is held low one clock after chan_en[i] is sampled 0.
- R7: The tone gate of a channel changes only when a tone period starts. A burst therefore always begins with a full 10·OSC_HALF-clock high phase, and no shortened pulse appears when the key changes.
- R8: A channel whose chan_en bit is sampled 0 drives tone_out low from the next clock, regardless of its continuous bit and keying pin.
- R9: While rst is high, all outputs are low from the first clock edge onward. After rst falls, the first tone period starts at the first clock edge.
- R10: A keying pin is sampled through two flops, so a level that is present at clock edge t is seen by the gate at edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the oscillator is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | NCH | Per-channel enable (converter and tone) |
| tone_on | input | NCH | Per-channel continuous-tone bit |
| key_in | input | NCH | Per-channel asynchronous burst keying pin |
| tone_out | output | NCH | Per-channel gated tone |
| conv_clk | output | NCH | Per-channel converter switching clock |

## Verification
Holding the continuous bit with the key toggling shows whether the key leaks into the continuous mode. The same run measures the tone's high time and period. Keying bursts that start part-way through a tone period show whether the gate waits for a period boundary or clips the first pulse. Runs where one channel is keyed while the other is idle or disabled show whether the channels are independent and whether the enable really masks the tone and the converter clock. Long random runs over all three controls are compared cycle by cycle with a reference that encodes the synchronizer delay and the period-boundary gating.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int TONE_RATIO  = 10;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic en;
    logic cont;
    logic key;
  } chan_ctl_t;

  function automatic int cnt_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/osc_prescale.sv
module osc_prescale
  import tone_pkg::*;
#(
  parameter int OSC_HALF = 1
) (
  input  logic clk,
  input  logic rst,
  output logic osc_sq,
  output logic osc_rise
);
  localparam int CW = cnt_w(OSC_HALF);
  localparam logic [CW-1:0] LAST = CW'(OSC_HALF - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = (cnt == LAST);
  assign osc_rise = tick & ~osc_sq;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= LAST;
      osc_sq <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) osc_sq <= ~osc_sq;
    end
  end
endmodule

// File: rtl/tone_divider.sv
module tone_divider
  import tone_pkg::*;
#(
  parameter int RATIO = TONE_RATIO
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_rise,
  output logic tone_sq,
  output logic period_start
);
  localparam int DW = cnt_w(RATIO);
  localparam logic [DW-1:0] WRAP = DW'(RATIO - 1);
  localparam logic [DW-1:0] HIGH = DW'(RATIO / 2);

  logic [DW-1:0] ocnt;
  logic [DW-1:0] ocnt_nxt;

  assign ocnt_nxt     = (ocnt == WRAP) ? '0 : ocnt + 1'b1;
  assign period_start = osc_rise && (ocnt == WRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt    <= WRAP;
      tone_sq <= 1'b0;
    end else if (osc_rise) begin
      ocnt    <= ocnt_nxt;
      tone_sq <= (ocnt_nxt < HIGH);
    end
  end
endmodule

// File: rtl/key_sync.sv
module key_sync
  import tone_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] d_async,
  output logic [NCH-1:0] d_sync
);
  logic [NCH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/chan_gate.sv
module chan_gate
  import tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  chan_ctl_t ctl,
  input  logic      period_start,
  input  logic      tone_sq,
  input  logic      osc_sq,
  output logic      tone_q,
  output logic      conv_q
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      tone_q <= 1'b0;
      conv_q <= 1'b0;
    end else begin
      if (period_start) gate_q <= ctl.en & (ctl.cont | ctl.key);
      tone_q <= ctl.en & gate_q & tone_sq;
      conv_q <= ctl.en & osc_sq;
    end
  end
endmodule

// File: rtl/tone_gate_gen.sv
module tone_gate_gen
  import tone_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int OSC_HALF = 1,
  parameter int RATIO    = TONE_RATIO
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] tone_on,
  input  logic [NCH-1:0] key_in,
  output logic [NCH-1:0] tone_out,
  output logic [NCH-1:0] conv_clk
);
  logic           osc_sq;
  logic           osc_rise;
  logic           tone_sq;
  logic           period_start;
  logic [NCH-1:0] key_s;

  osc_prescale #(.OSC_HALF(OSC_HALF)) u_osc (
    .clk(clk), .rst(rst), .osc_sq(osc_sq), .osc_rise(osc_rise)
  );

  tone_divider #(.RATIO(RATIO)) u_div (
    .clk(clk), .rst(rst), .osc_rise(osc_rise),
    .tone_sq(tone_sq), .period_start(period_start)
  );

  key_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(key_in), .d_sync(key_s)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    chan_ctl_t ctl;
    assign ctl = '{en: chan_en[i], cont: tone_on[i], key: key_s[i]};

    chan_gate u_gate (
      .clk(clk), .rst(rst), .ctl(ctl),
      .period_start(period_start), .tone_sq(tone_sq), .osc_sq(osc_sq),
      .tone_q(tone_out[i]), .conv_q(conv_clk[i])
    );
  end
endmodule

// File: rtl/tone_gate_checker.sv
module tone_gate_checker #(
  parameter int NCH      = 2,
  parameter int OSC_HALF = 1,
  parameter int RATIO    = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] tone_on,
  input logic [NCH-1:0] key_in,
  input logic [NCH-1:0] tone_out,
  input logic [NCH-1:0] conv_clk
);
  localparam int HALF_CLKS = RATIO * OSC_HALF;
  localparam int LONG      = 2 * HALF_CLKS * 2 + 4;
  localparam int AW        = $clog2(LONG + 2);

  // R9: reset keeps every output low
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (tone_out == '0 && conv_clk == '0));

  // R5: enabled channels share one converter phase
  a_r5_conv_aligned: assert property (@(posedge clk) disable iff (rst)
    (&chan_en) |=> (conv_clk == '0 || conv_clk == '1));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [AW-1:0] hi_cnt;
    logic [AW-1:0] en_age;

    always_ff @(posedge clk) begin
      if (rst) begin
        hi_cnt <= '0;
        en_age <= '0;
      end else begin
        hi_cnt <= tone_out[i] ? ((hi_cnt == AW'(LONG)) ? hi_cnt : hi_cnt + 1'b1) : '0;
        en_age <= chan_en[i]  ? ((en_age == AW'(LONG)) ? en_age : en_age + 1'b1) : '0;
      end
    end

    // R8: disabled channel carries no tone
    a_r8_tone_quiet_off: assert property (@(posedge clk) disable iff (rst)
      !chan_en[i] |=> !tone_out[i]);

    // R6: disabled channel has no converter clock
    a_r6_conv_quiet_off: assert property (@(posedge clk) disable iff (rst)
      !chan_en[i] |=> !conv_clk[i]);

    // R2 and R7: with the channel steadily enabled, every high phase is full length
    a_r2_full_high: assert property (@(posedge clk) disable iff (rst)
      ($fell(tone_out[i]) && en_age >= AW'(2 * HALF_CLKS + 2)) |-> (hi_cnt == AW'(HALF_CLKS)));
  end
endmodule

bind tone_gate_gen tone_gate_checker #(
  .NCH(NCH), .OSC_HALF(OSC_HALF), .RATIO(RATIO)
) u_tone_gate_checker (
  .clk(clk), .rst(rst), .chan_en(chan_en), .tone_on(tone_on),
  .key_in(key_in), .tone_out(tone_out), .conv_clk(conv_clk)
);

// File: tb/test_tone_gate_gen.sv
module test_tone_gate_gen;
  localparam int NCH      = 2;
  localparam int OSC_HALF = 1;
  localparam int RATIO    = 10;
  localparam int HI_CLKS  = RATIO * OSC_HALF;
  localparam int PER_CLKS = 2 * RATIO * OSC_HALF;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH-1:0] tone_on = '0;
  logic [NCH-1:0] key_in  = '0;
  logic [NCH-1:0] tone_out;
  logic [NCH-1:0] conv_clk;

  int checks = 0;
  int fails  = 0;
  bit mcheck = 1'b0;

  always #4 clk = ~clk;

  tone_gate_gen #(.NCH(NCH), .OSC_HALF(OSC_HALF), .RATIO(RATIO)) i_tone_gate_gen (
    .clk(clk), .rst(rst), .chan_en(chan_en), .tone_on(tone_on),
    .key_in(key_in), .tone_out(tone_out), .conv_clk(conv_clk)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int             m_k;
  logic [NCH-1:0] m_f1, m_f2, m_gate, m_out, m_conv;
  logic           m_sq, m_osc;

  function automatic logic ref_sq(input int k);
    return (((k - 1) / (2 * OSC_HALF)) % RATIO) < (RATIO / 2);
  endfunction

  always @(posedge clk) begin
    int kk;
    if (rst) begin
      m_k <= 0; m_f1 <= '0; m_f2 <= '0; m_gate <= '0;
      m_out <= '0; m_conv <= '0; m_sq <= 1'b0; m_osc <= 1'b0;
    end else begin
      kk = m_k + 1;
      m_k  <= kk;
      m_f1 <= key_in;
      m_f2 <= m_f1;
      if ((kk - 1) % PER_CLKS == 0) m_gate <= chan_en & (tone_on | m_f2);
      m_out  <= chan_en & m_gate & {NCH{m_sq}};
      m_conv <= chan_en & {NCH{m_osc}};
      m_sq   <= ref_sq(kk);
      m_osc  <= (((kk - 1) / OSC_HALF) % 2) == 0;
    end
  end

  always @(negedge clk) begin
    if (mcheck && !rst) begin
      for (int c = 0; c < NCH; c++) begin
        string tg;
        if (!chan_en[c])     tg = "R8";
        else if (tone_on[c]) tg = "R3";
        else                 tg = "R4 R10";
        check(tone_out[c] === m_out[c], tg, int'(tone_out[c]), int'(m_out[c]));
        check(conv_clk[c] === m_conv[c], "R6", int'(conv_clk[c]), int'(m_conv[c]));
      end
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int t;
    hi = 0; per = 0; t = 0;
    while (tone_out[ch] && t < 200) begin @(negedge clk); t++; end
    while (!tone_out[ch] && t < 400) begin @(negedge clk); t++; end
    while (tone_out[ch] && t < 600) begin @(negedge clk); hi++; t++; end
    per = hi;
    while (!tone_out[ch] && t < 800) begin @(negedge clk); per++; t++; end
  endtask

  initial begin
    int hi, per, seed;
    seed = $urandom(32'd4242);
    // reset state
    cycles(3);
    check(tone_out == '0, "R9", int'(tone_out), 0);
    check(conv_clk == '0, "R9", int'(conv_clk), 0);
    @(negedge clk);
    rst = 1'b0;
    mcheck = 1'b1;

    // continuous tone on both channels while keys toggle
    chan_en = '1; tone_on = '1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      key_in = NCH'($urandom);
    end
    measure(0, hi, per);
    check(hi == HI_CLKS, "R2", hi, HI_CLKS);
    check(per == PER_CLKS, "R1", per, PER_CLKS);
    check(tone_out[0] == tone_out[1], "R5", int'(tone_out[1]), int'(tone_out[0]));

    // burst keying started mid-period on channel 0 only
    tone_on = '0; key_in = '0;
    cycles(3 * PER_CLKS);
    cycles(7);
    key_in = 2'b01;
    measure(0, hi, per);
    check(hi == HI_CLKS, "R7", hi, HI_CLKS);
    check(per == PER_CLKS, "R1", per, PER_CLKS);
    check(tone_out[1] == 1'b0, "R5", int'(tone_out[1]), 0);
    // drop the key in the middle of a high phase
    while (!tone_out[0]) @(negedge clk);
    cycles(3);
    key_in = '0;
    cycles(HI_CLKS - 4);
    check(tone_out[0] == 1'b1, "R7", int'(tone_out[0]), 1);
    cycles(2 * PER_CLKS);
    check(tone_out[0] == 1'b0, "R4", int'(tone_out[0]), 0);

    // disabled channel with continuous bit and key set
    chan_en = 2'b01; tone_on = 2'b10; key_in = 2'b11;
    for (int i = 0; i < 3 * PER_CLKS; i++) begin
      @(negedge clk);
      check(tone_out[1] == 1'b0 && conv_clk[1] == 1'b0, "R8",
            int'({tone_out[1], conv_clk[1]}), 0);
    end

    // random mix
    chan_en = '1; tone_on = '0; key_in = '0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(99) < 6)  key_in[c]  = ~key_in[c];
        if ($urandom_range(999) < 8) tone_on[c] = ~tone_on[c];
        if ($urandom_range(999) < 5) chan_en[c] = ~chan_en[c];
      end
    end
    cycles(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule